// File: doc/BRIEF.md
# GPIO Interrupt Detector

This block watches a bank of general-purpose input pads and turns selected levels or edges on them into interrupt requests. Each pad is first brought into the clock domain by a two-stage synchronizer. The synchronized value is then compared with its value one cycle earlier, so each pin can sense an active level, a rising edge, a falling edge or, where the pin supports it, either edge. A hit is recorded in a sticky per-pin status bit, and software clears that bit later.

Every pin has three registers behind a simple write/read port: a configuration word, a status word and a routing word. The configuration word sets whether hits are recorded, whether a recorded hit may raise the shared request line, the detection type and the polarity. The routing word holds a 3-bit destination code. A single summary output rises while any pin meets three conditions at once: its status is set, its request enable is set, and its destination equals the application-processor code. At build time, a per-pin parameter chooses between a 2-bit detection field and a 1-bit detection field. A second per-pin parameter chooses whether writing one or writing zero acknowledges that pin's status.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every configuration, status and routing register reads zero. The summary output `irq_out` is low for as long as `rst_n` is low.
- R2: A pin records hits only while its record-enable bit (configuration bit 0) is 1. While that bit is 0, no pad activity sets the pin's status, and `irq_out` stays low.
- R3: `irq_out` is the OR, over all pins, of a three-way AND: status set, request-enable bit (configuration bit 1) set, and routing match. A pin whose status is set but whose request-enable bit is clear does not raise `irq_out`.
- R4: On a pin built with the 2-bit detection field (configuration bits 3:2), the field values mean: 0 level, 1 rising edge, 2 falling edge, 3 either edge. The polarity bit has no effect on the edge types.
- R5: In level sensing, polarity bit 4 selects the active level: 1 means high is active and 0 means low is active. This holds for both field widths.
- R6: On a pin built with the 1-bit detection field, bit 2 selects edge (1) or level (0), and bit 3 has no effect. For edges, polarity 1 senses rising and polarity 0 senses falling.
- R7: A write to a pin's status register acknowledges that pin, clearing its status, when write-data bit 0 equals the pin's acknowledge value (parameter `ACK_ONE_MASK`, one bit per pin). A write of the opposite value leaves the status unchanged.
- R8: If a level-sensing pin is acknowledged while its active level is still on the pad and recording is enabled, its status stays set.
- R9: Status is sticky. When a hit and an acknowledge reach the same pin in the same cycle, the status ends up set.
- R10: An edge that arrives while the request-enable bit is clear is still recorded. It raises `irq_out` as soon as that bit is set.
- R11: A pad change reaches status on the third rising clock edge after the pad changes, and not on the second.
- R12: Only pins whose 3-bit routing field equals `APP_TARGET` contribute to `irq_out`.
- R13: The register address is {pin index, selector}, with the selector in the two low bits: 0 configuration, 1 status, 2 routing, 3 reserved. The configuration word uses bits 4:0, status uses bit 0 and routing uses bits 2:0. All other bits read zero, and the reserved selector reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pad_in | input | NUM_PINS | Asynchronous pad inputs, one per pin |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | $clog2(NUM_PINS)+2 | Register address: pin index above a 2-bit selector |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr`, combinational |
| irq_out | output | 1 | Summary interrupt request |

## Verification
The bench builds the block with four pins: pins 0 and 1 use the 2-bit detection field and pins 2 and 3 use the 1-bit field. Acknowledge-by-one is set on pins 0 and 2, and acknowledge-by-zero on pins 1 and 3. With this configuration, one sweep covers every pin, every detection-field value, both polarities and both starting pad levels. That reaches both encodings and both acknowledge senses. The same small build leaves room for directed cases: hit-versus-acknowledge in the same cycle, routing mismatch, recording while the request enable is clear, and reset with a request pending.

// File: rtl/gpio_irq_pkg.sv
// Package: shared types and field layout for the GPIO interrupt detector.
// Assumes the data bus is at least as wide as the configuration word.
package gpio_irq_pkg;

    // Per-pin configuration word; packed MSB first so bit 0 is record enable.
    typedef struct packed {
        logic       polarity;   // bit 4: active level / edge sense
        logic [1:0] detect;     // bits 3:2: detection type
        logic       irq_en;     // bit 1: may raise the summary line
        logic       raw_en;     // bit 0: hits are recorded into status
    } pin_cfg_t;

    localparam int CFG_W = $bits(pin_cfg_t);

    // Register selector carried in the two low address bits.
    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_TGT  = 2'd2,
        SEL_RSVD = 2'd3
    } reg_sel_e;

    // Encodings of the 2-bit detection field.
    localparam logic [1:0] DET_LEVEL = 2'd0;
    localparam logic [1:0] DET_RISE  = 2'd1;
    localparam logic [1:0] DET_FALL  = 2'd2;
    localparam logic [1:0] DET_BOTH  = 2'd3;

endpackage

// File: rtl/gpio_irq_sync.sv
// Module: two-stage pad synchronizer plus a one-cycle history register.
// What it does: brings asynchronous pads into the clock domain and keeps the
// previous synchronized value so edges can be found by comparison.
// Assumes: pads are slow compared with the clock (one sample per level).
module gpio_irq_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] hist_q;

    // Shift pads through two sync stages and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pad_i;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign cur_o  = sync_q;
    assign prev_o = hist_q;

endmodule

// File: rtl/gpio_irq_pin.sv
// Module: detection logic and sticky status bit for one pin.
// What it does: decodes the pin configuration into a hit condition from the
// current and previous synchronized values, and keeps the status flag.
// Assumes: cur_i/prev_i are consecutive samples of the same synchronized pad.
// WIDE_DET selects the 2-bit detection field; otherwise only bit 0 of the
// field is used (edge/level) and polarity picks the edge direction.
module gpio_irq_pin
    import gpio_irq_pkg::*;
#(
    parameter bit WIDE_DET = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  pin_cfg_t cfg_i,
    input  logic     cur_i,
    input  logic     prev_i,
    input  logic     ack_i,
    output logic     hit_o,
    output logic     status_o
);

    logic rise;
    logic fall;
    logic lvl_active;
    logic trig;
    logic status_q;
    logic cfg_unused;

    assign rise       = cur_i & ~prev_i;
    assign fall       = ~cur_i & prev_i;
    assign lvl_active = (cur_i == cfg_i.polarity);
    assign cfg_unused = cfg_i.irq_en;

    generate
        if (WIDE_DET) begin : g_wide
            // Decode the 2-bit field; polarity only matters for level.
            always_comb begin
                unique case (cfg_i.detect)
                    DET_LEVEL: trig = lvl_active;
                    DET_RISE:  trig = rise;
                    DET_FALL:  trig = fall;
                    default:   trig = rise | fall;
                endcase
            end
        end else begin : g_narrow
            logic det_hi_unused;
            assign det_hi_unused = cfg_i.detect[1];
            // Decode the 1-bit field; polarity picks level or edge direction.
            always_comb begin
                if (cfg_i.detect[0]) begin
                    trig = cfg_i.polarity ? rise : fall;
                end else begin
                    trig = lvl_active;
                end
            end
        end
    endgenerate

    assign hit_o = cfg_i.raw_en & trig;

    // Sticky status: a hit sets it and outranks a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (hit_o) begin
            status_q <= 1'b1;
        end else if (ack_i) begin
            status_q <= 1'b0;
        end
    end

    assign status_o = status_q;

endmodule

// File: rtl/gpio_irq_regfile.sv
// Module: configuration and routing registers with write decode and read mux.
// What it does: stores per-pin configuration and destination, turns status
// writes into per-pin acknowledge strobes, and returns read data.
// Assumes: DATA_W >= CFG_W; address = {pin index, 2-bit selector}.
module gpio_irq_regfile
    import gpio_irq_pkg::*;
#(
    parameter int                    NUM_PINS     = 4,
    parameter int                    DATA_W       = 8,
    parameter int                    TGT_W        = 3,
    parameter int                    ADDR_W       = 4,
    parameter logic [NUM_PINS-1:0]   ACK_ONE_MASK = '1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_wr,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic [DATA_W-1:0]              reg_wdata,
    input  logic [NUM_PINS-1:0]            status_i,
    output pin_cfg_t [NUM_PINS-1:0]        cfg_o,
    output logic [NUM_PINS-1:0][TGT_W-1:0] tgt_o,
    output logic [NUM_PINS-1:0]            ack_o,
    output logic [DATA_W-1:0]              reg_rdata
);

    localparam int PIN_IDX_W = ADDR_W - 2;

    logic [PIN_IDX_W-1:0] addr_pin;
    reg_sel_e             addr_sel;
    logic                 wdata_unused;

    assign addr_pin     = reg_addr[ADDR_W-1:2];
    assign addr_sel     = reg_sel_e'(reg_addr[1:0]);
    assign wdata_unused = ^reg_wdata[DATA_W-1:CFG_W];

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
            logic     pin_sel;
            pin_cfg_t cfg_q;
            logic [TGT_W-1:0] tgt_q;

            assign pin_sel = reg_wr && (addr_pin == PIN_IDX_W'(gi));

            // Capture configuration and routing writes for this pin.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cfg_q <= '0;
                    tgt_q <= '0;
                end else if (pin_sel) begin
                    if (addr_sel == SEL_CFG) begin
                        cfg_q <= pin_cfg_t'(reg_wdata[CFG_W-1:0]);
                    end
                    if (addr_sel == SEL_TGT) begin
                        tgt_q <= reg_wdata[TGT_W-1:0];
                    end
                end
            end

            assign cfg_o[gi] = cfg_q;
            assign tgt_o[gi] = tgt_q;
            assign ack_o[gi] = pin_sel && (addr_sel == SEL_STAT) &&
                               (reg_wdata[0] == ACK_ONE_MASK[gi]);
        end
    endgenerate

    // Return the addressed register, zero-extended; reserved reads zero.
    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (addr_pin == PIN_IDX_W'(p)) begin
                unique case (addr_sel)
                    SEL_CFG:  reg_rdata[CFG_W-1:0] = cfg_o[p];
                    SEL_STAT: reg_rdata[0]         = status_i[p];
                    SEL_TGT:  reg_rdata[TGT_W-1:0] = tgt_o[p];
                    default:  reg_rdata            = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: top of the GPIO interrupt detector.
// What it does: synchronizes the pads, runs one detector per pin, holds the
// registers, and drives the summary request for pins routed to APP_TARGET.
// Assumes: NUM_PINS >= 2; WIDE_MASK / ACK_ONE_MASK give one bit per pin.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int                  NUM_PINS     = 4,
    parameter int                  DATA_W       = 8,
    parameter int                  TGT_W        = 3,
    parameter int                  APP_TARGET   = 4,
    parameter logic [NUM_PINS-1:0] WIDE_MASK    = '1,
    parameter logic [NUM_PINS-1:0] ACK_ONE_MASK = '1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PINS-1:0]           pad_in,
    input  logic                          reg_wr,
    input  logic [$clog2(NUM_PINS)+1:0]   reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    output logic                          irq_out
);

    localparam int ADDR_W = $clog2(NUM_PINS) + 2;

    logic [NUM_PINS-1:0]            cur_w;
    logic [NUM_PINS-1:0]            prev_w;
    logic [NUM_PINS-1:0]            hit_w;
    logic [NUM_PINS-1:0]            ack_w;
    logic [NUM_PINS-1:0]            status_q;
    logic [NUM_PINS-1:0]            irq_en_q;
    logic [NUM_PINS-1:0]            raw_en_q;
    logic [NUM_PINS-1:0]            pend_w;
    pin_cfg_t [NUM_PINS-1:0]        cfg_w;
    logic [NUM_PINS-1:0][TGT_W-1:0] tgt_w;

    gpio_irq_sync #(.WIDTH(NUM_PINS)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_i  (pad_in),
        .cur_o  (cur_w),
        .prev_o (prev_w)
    );

    gpio_irq_regfile #(
        .NUM_PINS     (NUM_PINS),
        .DATA_W       (DATA_W),
        .TGT_W        (TGT_W),
        .ADDR_W       (ADDR_W),
        .ACK_ONE_MASK (ACK_ONE_MASK)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status_i  (status_q),
        .cfg_o     (cfg_w),
        .tgt_o     (tgt_w),
        .ack_o     (ack_w),
        .reg_rdata (reg_rdata)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
            gpio_irq_pin #(.WIDE_DET(WIDE_MASK[gi])) pin_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .cfg_i    (cfg_w[gi]),
                .cur_i    (cur_w[gi]),
                .prev_i   (prev_w[gi]),
                .ack_i    (ack_w[gi]),
                .hit_o    (hit_w[gi]),
                .status_o (status_q[gi])
            );
            assign irq_en_q[gi] = cfg_w[gi].irq_en;
            assign raw_en_q[gi] = cfg_w[gi].raw_en;
            assign pend_w[gi]   = status_q[gi] & irq_en_q[gi] &
                                  (tgt_w[gi] == TGT_W'(APP_TARGET));
        end
    endgenerate

    assign irq_out = rst_n & (|pend_w);

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
// Module: assertion checker for gpio_irq_ctrl, attached by bind below.
// What it does: checks status stickiness, acknowledge, record gating and the
// summary line against the pending state.
module gpio_irq_ctrl_chk #(
    parameter int NUM_PINS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                irq_out,
    input logic [NUM_PINS-1:0] status_q,
    input logic [NUM_PINS-1:0] irq_en_q,
    input logic [NUM_PINS-1:0] raw_en_q,
    input logic [NUM_PINS-1:0] hit_w,
    input logic [NUM_PINS-1:0] ack_w
);

    assert_summary_needs_pending_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        irq_out |-> (|(status_q & irq_en_q)));

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
            assert_no_record_without_raw_R2: assert property (
                @(posedge clk) disable iff (!rst_n)
                (!raw_en_q[gi] && !status_q[gi]) |=> !status_q[gi]);

            assert_ack_clears_R7: assert property (
                @(posedge clk) disable iff (!rst_n)
                (ack_w[gi] && !hit_w[gi]) |=> !status_q[gi]);

            assert_hit_wins_R9: assert property (
                @(posedge clk) disable iff (!rst_n)
                hit_w[gi] |=> status_q[gi]);

            assert_status_sticky_R9: assert property (
                @(posedge clk) disable iff (!rst_n)
                (status_q[gi] && !ack_w[gi]) |=> status_q[gi]);
        end
    endgenerate

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_out  (irq_out),
    .status_q (status_q),
    .irq_en_q (irq_en_q),
    .raw_en_q (raw_en_q),
    .hit_w    (hit_w),
    .ack_w    (ack_w)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
// Bench: sweeps every pin, detection value, polarity and start level on a
// four-pin build, then runs directed cases. Expected values are computed here.
module gpio_irq_ctrl_tb_top;

    localparam int         NP       = 4;
    localparam logic [3:0] WIDE     = 4'b0011;
    localparam logic [3:0] ACK_ONE  = 4'b0101;
    localparam int         APP      = 4;
    localparam int         S_CFG    = 0;
    localparam int         S_STAT   = 1;
    localparam int         S_TGT    = 2;
    localparam int         S_RSVD   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pad = '0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_out;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    gpio_irq_ctrl #(
        .NUM_PINS     (NP),
        .DATA_W       (8),
        .TGT_W        (3),
        .APP_TARGET   (APP),
        .WIDE_MASK    (WIDE),
        .ACK_ONE_MASK (ACK_ONE)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_in    (pad),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int pin, input int sel, input int data);
        @(negedge clk);
        reg_addr  = 4'((pin << 2) | sel);
        reg_wdata = 8'(data);
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input int pin, input int sel, output int data);
        reg_addr = 4'((pin << 2) | sel);
        #1;
        data = int'(reg_rdata);
    endtask

    task automatic set_pad(input int pin, input int v);
        @(negedge clk);
        pad[pin] = v[0];
    endtask

    function automatic int cfg_word(int raw, int en, int det, int pol);
        return raw | (en << 1) | (det << 2) | (pol << 4);
    endfunction

    function automatic int ack_of(int pin);
        return int'(ACK_ONE[pin]);
    endfunction

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 / R13: reset values and reserved selector.
        for (int p = 0; p < NP; p++) begin
            for (int s = 0; s < 4; s++) begin
                rd(p, s, v);
                chk(v, 0, "R1", "register after reset");
            end
        end
        chk(int'(irq_out), 0, "R1", "irq_out after reset");

        // R13: field widths and unused bits.
        wr(0, S_CFG, 8'hFF);
        rd(0, S_CFG, v);
        chk(v, 8'h1F, "R13", "config readback");
        wr(0, S_CFG, 0);
        wr(1, S_TGT, 8'hFF);
        rd(1, S_TGT, v);
        chk(v, 8'h07, "R13", "routing readback");
        rd(1, S_RSVD, v);
        chk(v, 0, "R13", "reserved selector");

        for (int p = 0; p < NP; p++) wr(p, S_TGT, APP);

        // Sweep: pin x detection value x polarity x start level.
        for (int p = 0; p < NP; p++) begin
            for (int det = 0; det < 4; det++) begin
                for (int pol = 0; pol < 2; pol++) begin
                    for (int st = 0; st < 2; st++) begin
                        bit lvl_mode;
                        int exp;
                        bit rising;
                        lvl_mode = WIDE[p] ? (det == 0) : ((det & 1) == 0);
                        rising = (st == 0);
                        wr(p, S_CFG, 0);
                        set_pad(p, st);
                        step(3);
                        wr(p, S_STAT, ack_of(p));
                        rd(p, S_STAT, v);
                        chk(v, 0, "R7", "status after acknowledge");
                        wr(p, S_CFG, cfg_word(1, 1, det, pol));
                        step(3);
                        if (lvl_mode) begin
                            exp = (st == pol) ? 1 : 0;
                            rd(p, S_STAT, v);
                            chk(v, exp, "R5", "level status");
                            chk(int'(irq_out), exp, "R3", "irq_out level");
                            if (exp == 1) begin
                                wr(p, S_STAT, ack_of(p));
                                rd(p, S_STAT, v);
                                chk(v, 1, "R8", "level re-latch after ack");
                            end
                            set_pad(p, 1 - st);
                            step(4);
                            rd(p, S_STAT, v);
                            chk(v, 1, "R5", "level status after toggle");
                        end else begin
                            if (WIDE[p]) begin
                                exp = (det == 1) ? int'(rising) :
                                      (det == 2) ? int'(!rising) : 1;
                            end else begin
                                exp = (pol == 1) ? int'(rising) : int'(!rising);
                            end
                            rd(p, S_STAT, v);
                            chk(v, 0, WIDE[p] ? "R4" : "R6", "no hit on stable pad");
                            set_pad(p, 1 - st);
                            step(2);
                            rd(p, S_STAT, v);
                            chk(v, 0, "R11", "status before third edge");
                            step(1);
                            rd(p, S_STAT, v);
                            chk(v, exp, WIDE[p] ? "R4" : "R6", "edge status");
                            chk(int'(irq_out), exp, "R3", "irq_out edge");
                        end
                        wr(p, S_CFG, 0);
                        wr(p, S_STAT, ack_of(p));
                        set_pad(p, 0);
                        step(3);
                    end
                end
            end
        end

        // R7: opposite value leaves status; acknowledge value clears it.
        for (int p = 1; p < 3; p++) begin
            wr(p, S_CFG, cfg_word(1, 1, 1, 1));
            set_pad(p, 1);
            step(4);
            rd(p, S_STAT, v);
            chk(v, 1, "R7", "status latched before ack");
            wr(p, S_STAT, 1 - ack_of(p));
            rd(p, S_STAT, v);
            chk(v, 1, "R7", "non-ack write ignored");
            wr(p, S_STAT, ack_of(p));
            rd(p, S_STAT, v);
            chk(v, 0, "R7", "ack write clears");
            wr(p, S_CFG, 0);
            set_pad(p, 0);
            step(3);
        end

        // R10 / R3: record while request disabled, then enable.
        wr(0, S_CFG, cfg_word(1, 0, 1, 1));
        set_pad(0, 1);
        step(4);
        rd(0, S_STAT, v);
        chk(v, 1, "R10", "recorded while disabled");
        chk(int'(irq_out), 0, "R3", "irq_out with enable clear");
        wr(0, S_CFG, cfg_word(1, 1, 1, 1));
        #1;
        chk(int'(irq_out), 1, "R10", "irq_out after enable");

        // R12: routing mismatch blocks the summary.
        wr(0, S_TGT, 3);
        #1;
        chk(int'(irq_out), 0, "R12", "irq_out wrong target");
        wr(0, S_TGT, APP);
        #1;
        chk(int'(irq_out), 1, "R12", "irq_out target restored");

        // R1: summary low during reset with request pending, registers cleared.
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(int'(irq_out), 0, "R1", "irq_out during reset");
        step(2);
        pad = '0;
        step(1);
        rst_n = 1'b1;
        step(1);
        rd(0, S_CFG, v);
        chk(v, 0, "R1", "config after mid-run reset");
        rd(0, S_STAT, v);
        chk(v, 0, "R1", "status after mid-run reset");
        rd(0, S_TGT, v);
        chk(v, 0, "R1", "routing after mid-run reset");
        step(3);

        // R2: no recording with record enable clear.
        wr(3, S_TGT, APP);
        wr(3, S_CFG, cfg_word(0, 1, 1, 1));
        set_pad(3, 1);
        step(4);
        rd(3, S_STAT, v);
        chk(v, 0, "R2", "status with record off");
        chk(int'(irq_out), 0, "R2", "irq_out with record off");
        wr(3, S_CFG, 0);
        set_pad(3, 0);
        step(3);

        // R9: hit and acknowledge in the same cycle; hit wins.
        wr(1, S_TGT, APP);
        wr(1, S_CFG, cfg_word(1, 1, 1, 1));
        step(2);
        set_pad(1, 1);
        step(1);
        wr(1, S_STAT, ack_of(1));
        rd(1, S_STAT, v);
        chk(v, 1, "R9", "hit wins over ack");
        chk(int'(irq_out), 1, "R9", "irq_out after collision");

        finish_run();
    end

endmodule